// File: doc/BRIEF.md
# Bayer Line-Buffered Demosaic

This block turns a raster stream of 8-bit raw colour-filter-array samples into 24-bit pixels holding blue, green and red, without storing a frame. It keeps exactly one earlier line in on-chip memory. For each new sample it forms a 2x2 window: the sample, the sample to its left, and the two stored samples from the line above at the same two columns. One window position holds red, one holds blue and two hold green. Red and blue are copied from their positions. Green is the rounded-down mean of the two green positions.

Input samples come with a valid strobe and two markers. One marks the first sample of a line, the other the first sample of a frame. Converted pixels leave as a push strobe with data and go into a downstream FIFO that feeds display timing. The block watches that FIFO's full, empty and read signals and keeps sticky flags for a push into a full FIFO and for a read from an empty one. The colour-filter phase is set by a parameter.

Top module: `debayer_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `ovf_flag` and `udf_flag` are 0.
- R2: The first line of a frame produces no output pixel. A frame starts with an accepted sample that has `in_sof` set, and that sample also starts a line. Each later accepted sample with `in_sol` set starts the next line.
- R3: On the second and later lines of a frame, column 0 produces no output. An accepted sample at column x, with 1 <= x <= LINE_W-1, produces one output pixel with `out_valid` high in the cycle after the edge that accepted it.
- R4: Colour positions are fixed by PHASE: 0 gives RGGB, 1 gives GRBG, 2 gives GBRG and 3 gives BGGR. For sample (x,y) of the frame, let a = x[0] xor PHASE[0] and b = y[0] xor PHASE[1]. The sample is red when a=0 and b=0, blue when a=1 and b=1, and green otherwise. `out_bgr` carries blue in [23:16], green in [15:8] and red in [7:0], taken from the window (x-1,y-1), (x,y-1), (x-1,y), (x,y).
- R5: Green is (g1+g2)>>1, worked out without losing the carry, so 255 and 255 give 255.
- R6: Samples beyond column LINE_W-1 of a line produce no output and are not stored. The next line sees only the first LINE_W samples.
- R7: A cycle with `in_valid` low is ignored, even when the markers or the data are set. It produces no output and changes neither the position nor the stored line.
- R8: `ovf_flag` becomes 1 in the cycle after any cycle where `out_valid` and `fifo_full` are both high, and it stays 1.
- R9: `udf_flag` becomes 1 in the cycle after any cycle where `fifo_rd` and `fifo_empty` are both high, and it stays 1.
- R10: An accepted start-of-frame sample clears both flags in the next cycle, unless an event of R8 or R9 happens in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Raw sample present |
| in_sol | input | 1 | Sample is first of a line |
| in_sof | input | 1 | Sample is first of a frame |
| in_pix | input | 8 | Raw sample |
| fifo_full | input | 1 | Downstream FIFO full |
| fifo_empty | input | 1 | Downstream FIFO empty |
| fifo_rd | input | 1 | Downstream FIFO read strobe |
| out_valid | output | 1 | Push strobe into the FIFO |
| out_bgr | output | 24 | Converted pixel {B,G,R} |
| ovf_flag | output | 1 | Sticky push-while-full flag |
| udf_flag | output | 1 | Sticky read-while-empty flag |

## Verification
Every result is due one edge after its cause. An accepted sample shows up as a pixel in the next cycle. A FIFO event or a start-of-frame clear shows up on the flags in the next cycle. The bench's model reads the inputs at each rising edge, builds the expected outputs for the state after that edge, and compares them with the design at the next falling edge, so each check lands exactly in the cycle its result is due. Two instances with different phases get the same stimulus, which runs bubbles with live markers, overlong lines, saturated samples and a frame restarted part-way through.

// File: rtl/debayer_pkg.sv
package debayer_pkg;
    typedef logic [7:0] raw_t;

    typedef struct packed {
        raw_t b;
        raw_t g;
        raw_t r;
    } bgr_t;
endpackage

// File: rtl/dbr_line_mem.sv
module dbr_line_mem #(
    parameter int DEPTH = 1280,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // read returns the value from the line before, write replaces it for the next line
    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end
endmodule

// File: rtl/dbr_cell.sv
module dbr_cell
    import debayer_pkg::*;
#(
    parameter int PHASE = 0
) (
    input  raw_t tl,
    input  raw_t tr,
    input  raw_t bl,
    input  raw_t br,
    input  logic x_odd,
    input  logic y_odd,
    output bgr_t px
);
    localparam logic PH_X = ((PHASE % 2) == 1);
    localparam logic PH_Y = (((PHASE / 2) % 2) == 1);

    logic red_right;
    logic red_bottom;
    raw_t g_a;
    raw_t g_b;
    logic [8:0] g_sum;

    always_comb begin
        red_right  = ((x_odd ^ PH_X) == 1'b0);
        red_bottom = ((y_odd ^ PH_Y) == 1'b0);
        if (red_bottom) begin
            px.r = red_right ? br : bl;
            px.b = red_right ? tl : tr;
            g_a  = red_right ? bl : br;
            g_b  = red_right ? tr : tl;
        end else begin
            px.r = red_right ? tr : tl;
            px.b = red_right ? bl : br;
            g_a  = red_right ? tl : tr;
            g_b  = red_right ? br : bl;
        end
        g_sum = {1'b0, g_a} + {1'b0, g_b};
        px.g  = g_sum[8:1];
    end
endmodule

// File: rtl/dbr_fifo_mon.sv
module dbr_fifo_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic full,
    input  logic rd,
    input  logic empty,
    input  logic clr,
    output logic ovf,
    output logic udf
);
    typedef struct packed {
        logic ovf;
        logic udf;
    } mon_t;

    mon_t st_d, st_q;

    always_comb begin
        st_d     = clr ? '0 : st_q;
        st_d.ovf = st_d.ovf | (push & full);
        st_d.udf = st_d.udf | (rd & empty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf = st_q.ovf;
    assign udf = st_q.udf;
endmodule

// File: rtl/debayer_top.sv
module debayer_top
    import debayer_pkg::*;
#(
    parameter int LINE_W = 1280,
    parameter int PHASE  = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sol,
    input  logic        in_sof,
    input  logic [7:0]  in_pix,
    input  logic        fifo_full,
    input  logic        fifo_empty,
    input  logic        fifo_rd,
    output logic        out_valid,
    output logic [23:0] out_bgr,
    output logic        ovf_flag,
    output logic        udf_flag
);
    localparam int CW = $clog2(LINE_W + 1);
    localparam int AW = (LINE_W > 1) ? $clog2(LINE_W) : 1;
    localparam logic [CW-1:0] LW = CW'(LINE_W);

    typedef struct packed {
        logic [CW-1:0] col;
        logic          odd_row;
        logic          have_prev;
        raw_t          left;
        raw_t          top_left;
        logic          valid;
        bgr_t          pix;
    } st_t;

    st_t st_d, st_q;

    logic [CW-1:0] col_nx;
    logic          odd_nx;
    logic          prev_nx;
    logic          in_rng;
    logic          wr_en;
    raw_t          above;
    bgr_t          cell_px;

    // position of the incoming sample
    always_comb begin
        if (in_sof || in_sol)  col_nx = '0;
        else if (st_q.col == LW) col_nx = LW;
        else                   col_nx = st_q.col + 1'b1;
        if (in_sof) begin
            odd_nx  = 1'b0;
            prev_nx = 1'b0;
        end else if (in_sol) begin
            odd_nx  = ~st_q.odd_row;
            prev_nx = 1'b1;
        end else begin
            odd_nx  = st_q.odd_row;
            prev_nx = st_q.have_prev;
        end
        in_rng = (col_nx < LW);
        wr_en  = in_valid && in_rng;
    end

    dbr_line_mem #(.DEPTH(LINE_W), .WIDTH(8)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .addr  (col_nx[AW-1:0]),
        .wdata (in_pix),
        .rdata (above)
    );

    dbr_cell #(.PHASE(PHASE)) u_cell (
        .tl    (st_q.top_left),
        .tr    (above),
        .bl    (st_q.left),
        .br    (in_pix),
        .x_odd (col_nx[0]),
        .y_odd (odd_nx),
        .px    (cell_px)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (in_valid) begin
            st_d.col       = col_nx;
            st_d.odd_row   = odd_nx;
            st_d.have_prev = prev_nx;
            if (in_rng) begin
                st_d.left     = in_pix;
                st_d.top_left = above;
                st_d.valid    = (col_nx != '0) && prev_nx;
                if (st_d.valid) st_d.pix = cell_px;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.col <= LW;
        end else begin
            st_q <= st_d;
        end
    end

    dbr_fifo_mon u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (st_q.valid),
        .full  (fifo_full),
        .rd    (fifo_rd),
        .empty (fifo_empty),
        .clr   (in_valid && in_sof),
        .ovf   (ovf_flag),
        .udf   (udf_flag)
    );

    assign out_valid = st_q.valid;
    assign out_bgr   = st_q.pix;
endmodule

// File: rtl/debayer_chk.sv
module debayer_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_sof,
    input logic fifo_full,
    input logic fifo_empty,
    input logic fifo_rd,
    input logic out_valid,
    input logic ovf_flag,
    input logic udf_flag
);
    a_r2_sof_no_out: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> !out_valid);

    a_r3_out_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    a_r7_idle_no_out: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r8_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fifo_full) |=> ovf_flag);

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(in_valid && in_sof)) |=> ovf_flag);

    a_r9_udf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && fifo_empty) |=> udf_flag);

    a_r9_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (udf_flag && !(in_valid && in_sof)) |=> udf_flag);

    a_r10_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !(out_valid && fifo_full)) |=> !ovf_flag);

    a_r10_udf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !(fifo_rd && fifo_empty)) |=> !udf_flag);
endmodule

bind debayer_top debayer_chk u_chk (.*);

// File: tb/tb_debayer_top.sv
module tb_debayer_top;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
    logic [7:0] in_pix = '0;
    logic fifo_full = 1'b0, fifo_empty = 1'b0, fifo_rd = 1'b0;
    logic [1:0] o_valid, o_ovf, o_udf;
    logic [23:0] o_bgr [2];

    always #2.5 clk = ~clk;

    debayer_top #(.LINE_W(W), .PHASE(0)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof),
        .in_pix(in_pix), .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
        .out_valid(o_valid[0]), .out_bgr(o_bgr[0]), .ovf_flag(o_ovf[0]), .udf_flag(o_udf[0]));

    debayer_top #(.LINE_W(W), .PHASE(2)) dut_b (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof),
        .in_pix(in_pix), .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
        .out_valid(o_valid[1]), .out_bgr(o_bgr[1]), .ovf_flag(o_ovf[1]), .udf_flag(o_udf[1]));

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference
    int prev_line [W];
    int cur_line [W];
    int m_col, m_y, m_hp;
    int e_valid, e_ovf, e_udf;
    int e_b [2], e_g [2], e_r [2];
    string why_idle, why_flag;
    int phases [2] = '{0, 2};

    function automatic int colour_at(int x, int y, int ph);
        int a, b;
        a = (x & 1) ^ (ph & 1);
        b = (y & 1) ^ ((ph >> 1) & 1);
        if (a == 0 && b == 0) return 0;
        if (a == 1 && b == 1) return 2;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            e_valid = 0; e_ovf = 0; e_udf = 0;
            m_col = W; m_y = 0; m_hp = 0;
            why_idle = "R1"; why_flag = "R1";
        end else begin
            int ev_o, ev_u;
            ev_o = e_valid & fifo_full;
            ev_u = fifo_rd & fifo_empty;
            why_flag = (ev_o | ev_u) ? "R8/R9" : "R8/R9 sticky";
            if (in_valid && in_sof) begin
                e_ovf = ev_o; e_udf = ev_u; why_flag = "R10";
            end else begin
                e_ovf = e_ovf | ev_o; e_udf = e_udf | ev_u;
            end
            e_valid = 0;
            why_idle = "R7";
            if (in_valid) begin
                if (in_sof) begin
                    m_col = 0; m_y = 0; m_hp = 0;
                end else if (in_sol) begin
                    for (int i = 0; i < W; i++) prev_line[i] = cur_line[i];
                    m_col = 0; m_y++; m_hp = 1;
                end else if (m_col < W) begin
                    m_col++;
                end
                if (m_col >= W) why_idle = "R6";
                else if (!m_hp) why_idle = "R2";
                else if (m_col == 0) why_idle = "R3";
                if (m_col < W) begin
                    if (m_col >= 1 && m_hp) begin
                        int px [4];
                        int xs [4];
                        int ys [4];
                        px = '{prev_line[m_col-1], prev_line[m_col], cur_line[m_col-1], int'(in_pix)};
                        xs = '{m_col-1, m_col, m_col-1, m_col};
                        ys = '{m_y-1, m_y-1, m_y, m_y};
                        e_valid = 1;
                        for (int k = 0; k < 2; k++) begin
                            int gs;
                            gs = 0;
                            for (int j = 0; j < 4; j++) begin
                                case (colour_at(xs[j], ys[j], phases[k]))
                                    0: e_r[k] = px[j];
                                    2: e_b[k] = px[j];
                                    default: gs += px[j];
                                endcase
                            end
                            e_g[k] = gs / 2;
                        end
                    end
                    cur_line[m_col] = int'(in_pix);
                end
            end
        end
    end

    task automatic check(string tag, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 2; k++) begin
                check(e_valid ? "R3 out_valid" : {why_idle, " out_valid"}, int'(o_valid[k]), e_valid);
                if (e_valid && o_valid[k]) begin
                    check("R4 blue", int'(o_bgr[k][23:16]), e_b[k]);
                    check("R5 green", int'(o_bgr[k][15:8]), e_g[k]);
                    check("R4 red", int'(o_bgr[k][7:0]), e_r[k]);
                end
                check({why_flag, " ovf_flag"}, int'(o_ovf[k]), e_ovf);
                check({why_flag, " udf_flag"}, int'(o_udf[k]), e_udf);
            end
        end
    end

    task automatic fifo_rand();
        fifo_full  = ($urandom_range(0, 9) < 1);
        fifo_empty = ($urandom_range(0, 9) < 1);
        fifo_rd    = ($urandom_range(0, 1) == 1);
    endtask

    // one accepted sample, with an optional bubble first carrying junk markers
    task automatic put(bit sol, bit sof, int pix, int bubble_pct);
        if ($urandom_range(0, 99) < bubble_pct) begin
            in_valid = 1'b0;
            in_sol = $urandom_range(0, 1);
            in_sof = $urandom_range(0, 1);
            in_pix = 8'($urandom);
            fifo_rand();
            @(negedge clk);
        end
        in_valid = 1'b1; in_sol = sol; in_sof = sof; in_pix = 8'(pix);
        fifo_rand();
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
    endtask

    // mode 0 random, 1 all 255, 2 alternating 0/255
    task automatic line(bit sof, int len, int mode, int bubble_pct);
        for (int x = 0; x < len; x++) begin
            int v;
            case (mode)
                1: v = 255;
                2: v = ((x + m_y) & 1) ? 255 : 0;
                default: v = int'($urandom_range(0, 255));
            endcase
            put(x == 0, sof && x == 0, v, bubble_pct);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", int'(o_valid[0]), 0);
        check("R1 ovf_flag", int'(o_ovf[0]), 0);
        check("R1 udf_flag", int'(o_udf[0]), 0);
        rst_n = 1'b1;
        fifo_full = 1'b0; fifo_empty = 1'b0; fifo_rd = 1'b0;
        // frame of random data, no bubbles, then with bubbles
        line(1, W, 0, 0);
        for (int l = 0; l < 3; l++) line(0, W, 0, 0);
        line(1, W, 0, 30);
        for (int l = 0; l < 4; l++) line(0, W, 0, 30);
        // saturated and alternating data, overlong lines (R6)
        line(1, W + 5, 1, 10);
        line(0, W + 3, 1, 10);
        line(0, W + 4, 2, 10);
        line(0, W, 2, 10);
        line(0, W, 0, 10);
        // frame restarted part-way through a line
        line(1, W, 0, 20);
        line(0, W / 2, 0, 20);
        line(1, W, 0, 20);
        for (int l = 0; l < 3; l++) line(0, W, 0, 20);
        // idle cycles with FIFO activity only
        repeat (40) begin
            fifo_rand();
            @(negedge clk);
        end
        line(1, W, 0, 0);
        line(0, W, 0, 0);
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule